// File: doc/BRIEF.md
# Delayed Calibration Pulse Generator

This block drives the calibration stimulus for a set of front-end boards. Software writes a word to a control register over a small register bus. Each bit of that word requests one action, and the bit clears itself on the next clock. The block has three delay channels:

- an injection pulse;
- an external pulse;
- a short calibration trigger strobe.

Each channel waits for its own programmed delay and then drives its output for a width fixed at build time. A fourth control bit broadcasts a one-cycle test trigger, together with a matching-trigger strobe, to all seven front ends at once.

The clock is assumed to be 80 MHz. One step of the injection or external delay (12.5 ns) is one cycle, and one step of the calibration-trigger delay (25 ns) is two cycles. A channel samples its delay register when it accepts a request. While it is still waiting or still pulsing, it ignores further requests of the same kind.

Top module: `cal_pulse_gen`

## Requirements
- R1: A write to address 0 loads the strobe bits: bit 0 requests an injection pulse, bit 1 an external pulse, bit 2 a calibration trigger, and bit 3 a test trigger. Each strobe is high for exactly the one cycle after the write, and address 0 always reads back as zero.
- R2: Address 1 holds the 5-bit injection delay. It reads back zero-extended and changes only on a write to address 1. Each unit adds one clock cycle of delay.
- R3: Address 2 holds the 5-bit external-pulse delay. It reads back zero-extended, and each unit adds one clock cycle of delay.
- R4: Address 3 holds the 4-bit calibration-trigger delay. It reads back zero-extended, and each unit adds two clock cycles of delay.
- R5: With a delay of zero, the output rises in the cycle after the strobe, which is two cycles after the control write. A delay of d steps moves the rise d×step cycles later.
- R6: Each injection pulse and each external pulse is high for exactly 4 cycles. The calibration trigger is high for exactly 1 cycle.
- R7: A request of one kind that arrives while that channel is waiting or pulsing is ignored. A channel takes a new request only from the cycle after its pulse ends.
- R8: A test-trigger request drives the trigger output and all 7 bits of the matching-trigger output high together, for the single cycle after the write.
- R9: After reset, all outputs are low and all delay registers read zero.
- R10: A channel uses the delay value in force when it accepts the request. A later write to that delay register does not move a pulse that is already pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock (80 MHz assumed) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Register write enable |
| bus_addr | input | 2 | Register address (0 control, 1 injection delay, 2 external delay, 3 trigger delay) |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| inj_pulse | output | 1 | Injection pulse to the front ends |
| ext_pulse | output | 1 | External pulse to the front ends |
| cal_trig | output | 1 | Delayed calibration trigger strobe |
| test_trig | output | 1 | Broadcast test trigger |
| test_match | output | 7 | Matching-trigger strobe, one bit per front end |

## Verification
The embedded assertions check the following on every cycle:

- each channel's high time when its output falls;
- that a zero-delay acceptance fires on the next cycle;
- that an output can rise only out of a pending or just-requested state;
- that strobes clear themselves;
- that a delay register holds unless it is addressed.

The exact arrival cycle for a non-zero delay, the two-cycle step of the trigger delay, and the dropping of requests that overlap a pending pulse depend on the history of bus writes, so only the bench scenarios can show them. The bench also shows that rewriting a delay during a pending pulse has no effect, because it predicts every output cycle from its own shadow of the delays and its own acceptance times.

// File: rtl/cal_pulse_pkg.sv
package cal_pulse_pkg;

  localparam int unsigned BUS_AW = 2;
  localparam int unsigned BUS_DW = 16;

  localparam logic [BUS_AW-1:0] ADDR_CTRL = 2'd0;
  localparam logic [BUS_AW-1:0] ADDR_INJ  = 2'd1;
  localparam logic [BUS_AW-1:0] ADDR_EXT  = 2'd2;
  localparam logic [BUS_AW-1:0] ADDR_CAL  = 2'd3;

  // strobe bit positions in the control word
  localparam int unsigned SB_INJ  = 0;
  localparam int unsigned SB_EXT  = 1;
  localparam int unsigned SB_CAL  = 2;
  localparam int unsigned SB_TEST = 3;
  localparam int unsigned NUM_SB  = 4;

  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_WAIT = 2'd1,
    CH_FIRE = 2'd2
  } chan_state_e;

endpackage

// File: rtl/cal_cfg_regs.sv
module cal_cfg_regs
  import cal_pulse_pkg::*;
#(
  parameter int unsigned INJ_W = 5,
  parameter int unsigned EXT_W = 5,
  parameter int unsigned CAL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [BUS_AW-1:0] addr_i,
  input  logic [BUS_DW-1:0] wdata_i,
  output logic [BUS_DW-1:0] rdata_o,
  output logic [NUM_SB-1:0] strb_o,
  output logic [INJ_W-1:0]  inj_dly_o,
  output logic [EXT_W-1:0]  ext_dly_o,
  output logic [CAL_W-1:0]  cal_dly_o
);

  logic [NUM_SB-1:0] strb_q, strb_d;
  logic [INJ_W-1:0]  inj_q, inj_d;
  logic [EXT_W-1:0]  ext_q, ext_d;
  logic [CAL_W-1:0]  cal_q, cal_d;
  logic              inj_en, ext_en, cal_en;

  assign inj_en = we_i && (addr_i == ADDR_INJ);
  assign ext_en = we_i && (addr_i == ADDR_EXT);
  assign cal_en = we_i && (addr_i == ADDR_CAL);

  always_comb begin
    strb_d = '0;
    if (we_i && (addr_i == ADDR_CTRL)) strb_d = wdata_i[NUM_SB-1:0];
    inj_d = wdata_i[INJ_W-1:0];
    ext_d = wdata_i[EXT_W-1:0];
    cal_d = wdata_i[CAL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q <= '0;
      inj_q  <= '0;
      ext_q  <= '0;
      cal_q  <= '0;
    end else begin
      strb_q <= strb_d;
      if (inj_en) inj_q <= inj_d;
      if (ext_en) ext_q <= ext_d;
      if (cal_en) cal_q <= cal_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_INJ: rdata_o[INJ_W-1:0] = inj_q;
      ADDR_EXT: rdata_o[EXT_W-1:0] = ext_q;
      ADDR_CAL: rdata_o[CAL_W-1:0] = cal_q;
      default:  rdata_o = '0;
    endcase
  end

  assign strb_o    = strb_q;
  assign inj_dly_o = inj_q;
  assign ext_dly_o = ext_q;
  assign cal_dly_o = cal_q;

  AST_STROBE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((|strb_q) && !(we_i && addr_i == ADDR_CTRL)) |=> (strb_q == '0)); // R1

  AST_INJ_DLY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !inj_en |=> $stable(inj_q)); // R2

endmodule

// File: rtl/cal_dly_chan.sv
module cal_dly_chan
  import cal_pulse_pkg::*;
#(
  parameter int unsigned DLY_W = 5,
  parameter int unsigned STEP  = 1,
  parameter int unsigned PW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             pulse_o,
  output logic             busy_o
);

  localparam int unsigned MAX_WAIT = ((1 << DLY_W) - 1) * STEP;
  localparam int unsigned MAX_CNT  = (MAX_WAIT > PW) ? MAX_WAIT : PW;
  localparam int unsigned CNT_W    = $clog2(MAX_CNT + 1);

  chan_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = (state_q != CH_IDLE) || req_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      CH_IDLE: begin
        if (req_i) begin
          if (dly_i == '0) begin
            state_d = CH_FIRE;
            cnt_d   = CNT_W'(PW - 1);
          end else begin
            state_d = CH_WAIT;
            cnt_d   = CNT_W'(dly_i) * CNT_W'(STEP) - CNT_W'(1);
          end
        end
      end
      CH_WAIT: begin
        if (cnt_q == '0) begin
          state_d = CH_FIRE;
          cnt_d   = CNT_W'(PW - 1);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      CH_FIRE: begin
        if (cnt_q == '0) state_d = CH_IDLE;
        else             cnt_d   = cnt_q - CNT_W'(1);
      end
      default: state_d = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CH_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign pulse_o = (state_q == CH_FIRE);
  assign busy_o  = (state_q != CH_IDLE);

  // checker: length of the current high run of the output
  logic [CNT_W:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_q <= '0;
    else if (pulse_o) run_q <= run_q + 1'b1;
    else              run_q <= '0;
  end

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_o) |-> (run_q == (CNT_W+1)'(PW))); // R6

  AST_ZERO_DLY_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CH_IDLE && req_i && dly_i == '0) |=> pulse_o); // R5

  AST_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> ($past(busy_o) || $past(req_i))); // R7

endmodule

// File: rtl/cal_pulse_gen.sv
module cal_pulse_gen
  import cal_pulse_pkg::*;
#(
  parameter int unsigned INJ_W  = 5,
  parameter int unsigned EXT_W  = 5,
  parameter int unsigned CAL_W  = 4,
  parameter int unsigned INJ_PW = 4,
  parameter int unsigned EXT_PW = 4,
  parameter int unsigned CAL_PW = 1,
  parameter int unsigned CAL_STEP = 2,
  parameter int unsigned N_FE   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic              inj_pulse,
  output logic              ext_pulse,
  output logic              cal_trig,
  output logic              test_trig,
  output logic [N_FE-1:0]   test_match
);

  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  logic [NUM_SB-1:0] strb;
  logic [INJ_W-1:0]  inj_dly;
  logic [EXT_W-1:0]  ext_dly;
  logic [CAL_W-1:0]  cal_dly;
  logic              inj_busy, ext_busy, cal_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  cal_cfg_regs #(.INJ_W(INJ_W), .EXT_W(EXT_W), .CAL_W(CAL_W)) u_regs (
    .clk(clk), .rst_n(rst_n_int), .we_i(bus_we), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .rdata_o(bus_rdata), .strb_o(strb),
    .inj_dly_o(inj_dly), .ext_dly_o(ext_dly), .cal_dly_o(cal_dly)
  );

  cal_dly_chan #(.DLY_W(INJ_W), .STEP(1), .PW(INJ_PW)) u_inj (
    .clk(clk), .rst_n(rst_n_int), .req_i(strb[SB_INJ]), .dly_i(inj_dly),
    .pulse_o(inj_pulse), .busy_o(inj_busy)
  );

  cal_dly_chan #(.DLY_W(EXT_W), .STEP(1), .PW(EXT_PW)) u_ext (
    .clk(clk), .rst_n(rst_n_int), .req_i(strb[SB_EXT]), .dly_i(ext_dly),
    .pulse_o(ext_pulse), .busy_o(ext_busy)
  );

  cal_dly_chan #(.DLY_W(CAL_W), .STEP(CAL_STEP), .PW(CAL_PW)) u_cal (
    .clk(clk), .rst_n(rst_n_int), .req_i(strb[SB_CAL]), .dly_i(cal_dly),
    .pulse_o(cal_trig), .busy_o(cal_busy)
  );

  assign test_trig = strb[SB_TEST];

  for (genvar g = 0; g < N_FE; g++) begin : g_match
    assign test_match[g] = strb[SB_TEST];
  end

  AST_TEST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n_int)
    (test_trig && !(bus_we && bus_addr == ADDR_CTRL)) |=> !test_trig); // R8

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n_int |-> !(inj_pulse || ext_pulse || cal_trig || test_trig)); // R9

endmodule

// File: tb/test_cal_pulse_gen.sv
module test_cal_pulse_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        inj_pulse, ext_pulse, cal_trig, test_trig;
  logic [6:0]  test_match;

  cal_pulse_gen i_cal_pulse_gen (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .inj_pulse(inj_pulse),
    .ext_pulse(ext_pulse), .cal_trig(cal_trig), .test_trig(test_trig),
    .test_match(test_match)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // shadow state, computed from the requirements
  int sh_dly [3];            // 0 inj, 1 ext, 2 cal
  int st_cyc [3];
  int en_cyc [3];
  int tt_cyc = -100;
  localparam int STEPS [3] = '{1, 1, 2};
  localparam int WIDTH [3] = '{4, 4, 1};
  localparam int MASK  [3] = '{31, 31, 15};

  function automatic bit in_win(int c, int s, int e);
    return (c >= s) && (c <= e);
  endfunction

  function automatic logic [15:0] exp_rd(logic [1:0] a);
    if (a == 2'd0) return 16'd0;
    return 16'(sh_dly[a - 1]);
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R2 R5 R6 R7 R10 inj", 16'(inj_pulse), 16'(in_win(cyc, st_cyc[0], en_cyc[0])));
    chk("R3 R5 R6 R7 ext",     16'(ext_pulse), 16'(in_win(cyc, st_cyc[1], en_cyc[1])));
    chk("R4 R6 R7 caltrig",    16'(cal_trig),  16'(in_win(cyc, st_cyc[2], en_cyc[2])));
    chk("R8 test_trig",        16'(test_trig), 16'(cyc == tt_cyc));
    chk("R8 test_match",       16'(test_match), (cyc == tt_cyc) ? 16'h7f : 16'h0);
    chk("R1 R2 R3 R4 rdata",   bus_rdata, exp_rd(bus_addr));
  endtask

  // one cycle: check the current outputs, then drive inputs for the next edge
  task automatic step(bit we, logic [1:0] a, logic [15:0] d);
    int k;
    int acc;
    @(negedge clk);
    check_all();
    bus_we = we; bus_addr = a; bus_wdata = d;
    k = cyc + 1;
    if (we) begin
      if (a == 2'd0) begin
        for (int c = 0; c < 3; c++) begin
          if (d[c]) begin
            acc = k + 1;
            if (acc >= en_cyc[c] + 2) begin
              st_cyc[c] = acc + sh_dly[c] * STEPS[c];
              en_cyc[c] = st_cyc[c] + WIDTH[c] - 1;
            end
          end
        end
        if (d[3]) tt_cyc = k;
      end else begin
        sh_dly[a - 1] = int'(d) & MASK[a - 1];
      end
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 2'(i), 16'd0);
  endtask

  initial begin
    for (int c = 0; c < 3; c++) begin
      sh_dly[c] = 0; st_cyc[c] = -100; en_cyc[c] = -100;
    end
    void'($urandom(32'd4711));
    // R9: reset state
    repeat (3) @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      bus_addr = 2'(a);
      #1;
      chk("R9 reset rdata", bus_rdata, 16'd0);
    end
    chk("R9 reset outputs", 16'({inj_pulse, ext_pulse, cal_trig, test_trig, test_match}), 16'd0);
    rst_n = 1'b1;
    idle(6);

    // R5: zero delay on all channels
    step(1'b1, 2'd0, 16'h0007);
    idle(8);
    // R2: maximum injection delay, R7: retrigger during pending, R10: rewrite delay
    step(1'b1, 2'd1, 16'hffff);
    step(1'b1, 2'd0, 16'h0001);
    idle(10);
    step(1'b1, 2'd0, 16'h0001);
    step(1'b1, 2'd1, 16'h0003);
    idle(30);
    step(1'b1, 2'd0, 16'h0001);
    idle(8);
    // R4: maximum trigger delay, two cycles per step
    step(1'b1, 2'd3, 16'h000f);
    step(1'b1, 2'd0, 16'h0004);
    idle(40);
    // R3: external delay with back-to-back requests; R8: test trigger
    step(1'b1, 2'd2, 16'h0007);
    step(1'b1, 2'd0, 16'h000a);
    step(1'b1, 2'd0, 16'h000a);
    idle(20);

    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      bit we;
      logic [1:0] a;
      logic [15:0] d;
      we = ($urandom_range(0, 2) == 0);
      a  = 2'($urandom_range(0, 3));
      d  = 16'($urandom);
      if (a != 2'd0 && $urandom_range(0, 3) == 0) d = 16'd0;
      step(we, a, d);
    end
    idle(80);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule